// File: doc/BRIEF.md
# Program Counter with Latched Upper Bytes

This block holds a 21-bit program counter that addresses bytes of program memory and always stays word aligned. Only the lowest byte can be reached directly by software. The middle byte (bits 15:8) and the top field (bits 20:16) change only through two holding latches: a high latch and an upper latch.

Software fills these latches first. A write to the low byte then moves both latches into the counter at once, so a computed jump lands as one atomic update. Going the other way, a read of the low byte copies the counter's current upper bits into the latches, where software can read them.

The counter also advances by one instruction word on each advance strobe. It takes a full target in one cycle on a direct load, as used by calls, gotos and branches. A direct load neither uses nor changes the latches.

Top module: `pc_latch_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `pc_o`, `hlat_o` and `ulat_o` are all zero.
- R2: When `adv_i` is the only strobe that affects the counter, `pc_o` rises by 2 on that clock edge. The sum is taken modulo 2^21, so 0x1FFFFE advances to 0.
- R3: Bit 0 of `pc_o` is always 0. Bit 0 of the written low byte and bit 0 of a direct-load target are dropped.
- R4: When `lo_wr_i` is high, `pc_o` on that clock edge becomes {upper latch[4:0], high latch, `lo_wdata_i` with bit 0 cleared}. The latch values used are the ones held before that edge. The write itself leaves both latches unchanged.
- R5: When `lo_rd_i` is high, the high latch takes `pc_o[15:8]` and the upper latch takes `pc_o[20:16]`, using the values held before that edge. `pc_o` is not changed by the read.
- R6: When `jmp_i` is high and `lo_wr_i` is low, `pc_o` becomes `jmp_tgt_i` with bit 0 cleared. The latches are neither used nor changed by the load.
- R7: `hlat_wr_i` loads all 8 bits of `hlat_wdata_i` into the high latch. `ulat_wr_i` loads `ulat_wdata_i[4:0]` into the upper latch. `ulat_o[7:5]` always reads 0. Latch writes never change `pc_o`.
- R8: The counter update takes one source per edge, in this priority: low-byte write, then direct load, then advance. With no strobe active, `pc_o` holds its value.
- R9: A direct latch write takes priority over the low-byte read copy for the same latch. The other latch still takes its copy.
- R10: `lo_o` always equals `pc_o[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_i | input | 1 | Advance the counter by one instruction word |
| jmp_i | input | 1 | Direct-load strobe |
| jmp_tgt_i | input | 21 | Direct-load target address |
| lo_wr_i | input | 1 | Low-byte write strobe |
| lo_wdata_i | input | 8 | Low-byte write data |
| lo_rd_i | input | 1 | Low-byte read strobe (copies the upper bits into the latches) |
| hlat_wr_i | input | 1 | High latch write strobe |
| hlat_wdata_i | input | 8 | High latch write data |
| ulat_wr_i | input | 1 | Upper latch write strobe |
| ulat_wdata_i | input | 8 | Upper latch write data (bits 4:0 are used) |
| pc_o | output | 21 | Current program counter |
| lo_o | output | 8 | Low byte of the counter |
| hlat_o | output | 8 | High latch contents |
| ulat_o | output | 8 | Upper latch contents, bits 7:5 zero |

## Verification
The hardest situation to reach from the ports is the one where several strobes meet on one edge. A low-byte write can coincide with a direct load and an advance while a latch write and a read copy compete for the same latch. The bench therefore sweeps all 64 combinations of the six strobes, several times over, with pseudo-random data and targets.

The wrap at the top address is reached with a direct load to 0x1FFFFE followed by an advance. The upper-latch padding is exercised by writing every 5-bit upper value with the unused bits set. Each such write is followed by a low-byte write, so the latch contents show up in the counter.

// File: rtl/pc_latch_unit.sv
module pc_latch_unit #(
  parameter int PC_W   = 21,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              jmp_i,
  input  logic [PC_W-1:0]   jmp_tgt_i,
  input  logic              lo_wr_i,
  input  logic [BYTE_W-1:0] lo_wdata_i,
  input  logic              lo_rd_i,
  input  logic              hlat_wr_i,
  input  logic [BYTE_W-1:0] hlat_wdata_i,
  input  logic              ulat_wr_i,
  input  logic [BYTE_W-1:0] ulat_wdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hlat_o,
  output logic [BYTE_W-1:0] ulat_o
);

  localparam int UP_W = PC_W - 2*BYTE_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(2);
  localparam logic [PC_W-1:0] ALIGN = ~PC_W'(1);

  logic [PC_W-1:0]   pc_q, pc_d;
  logic [BYTE_W-1:0] hlat_q, hlat_d;
  logic [UP_W-1:0]   ulat_q, ulat_d;

  always_comb begin
    if (lo_wr_i)    pc_d = {ulat_q, hlat_q, lo_wdata_i} & ALIGN;
    else if (jmp_i) pc_d = jmp_tgt_i & ALIGN;
    else if (adv_i) pc_d = pc_q + STEP;
    else            pc_d = pc_q;
  end

  always_comb begin
    hlat_d = hlat_q;
    ulat_d = ulat_q;
    if (lo_rd_i) begin
      hlat_d = pc_q[2*BYTE_W-1:BYTE_W];
      ulat_d = pc_q[PC_W-1:2*BYTE_W];
    end
    if (hlat_wr_i) hlat_d = hlat_wdata_i;
    if (ulat_wr_i) ulat_d = ulat_wdata_i[UP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      hlat_q <= '0;
      ulat_q <= '0;
    end else begin
      pc_q   <= pc_d;
      hlat_q <= hlat_d;
      ulat_q <= ulat_d;
    end
  end

  assign pc_o   = pc_q;
  assign lo_o   = pc_q[BYTE_W-1:0];
  assign hlat_o = hlat_q;
  assign ulat_o = {{(BYTE_W-UP_W){1'b0}}, ulat_q};

endmodule

module pc_latch_unit_chk #(
  parameter int PC_W   = 21,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv_i,
  input logic              jmp_i,
  input logic [PC_W-1:0]   jmp_tgt_i,
  input logic              lo_wr_i,
  input logic [BYTE_W-1:0] lo_wdata_i,
  input logic              lo_rd_i,
  input logic              hlat_wr_i,
  input logic [BYTE_W-1:0] hlat_wdata_i,
  input logic              ulat_wr_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [BYTE_W-1:0] hlat_o,
  input logic [BYTE_W-1:0] ulat_o
);
  localparam int UP_W = PC_W - 2*BYTE_W;

  p_lsb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[0] == 1'b0);

  p_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !jmp_i && !lo_wr_i) |=> pc_o == PC_W'($past(pc_o) + PC_W'(2)));

  p_lo_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_i |=> pc_o == ({$past(ulat_o[UP_W-1:0]), $past(hlat_o), $past(lo_wdata_i)} & ~PC_W'(1)));

  p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_i && !lo_wr_i) |=> pc_o == ($past(jmp_tgt_i) & ~PC_W'(1)));

  p_read_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd_i && !hlat_wr_i) |=> hlat_o == $past(pc_o[2*BYTE_W-1:BYTE_W]));

  p_hlat_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hlat_wr_i |=> hlat_o == $past(hlat_wdata_i));

  p_ulat_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ulat_o[BYTE_W-1:UP_W] == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !jmp_i && !lo_wr_i) |=> $stable(pc_o));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_rd_i && !hlat_wr_i && !ulat_wr_i) |=> ($stable(hlat_o) && $stable(ulat_o)));
endmodule

bind pc_latch_unit pc_latch_unit_chk #(.PC_W(PC_W), .BYTE_W(BYTE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .jmp_i(jmp_i), .jmp_tgt_i(jmp_tgt_i),
  .lo_wr_i(lo_wr_i), .lo_wdata_i(lo_wdata_i), .lo_rd_i(lo_rd_i),
  .hlat_wr_i(hlat_wr_i), .hlat_wdata_i(hlat_wdata_i), .ulat_wr_i(ulat_wr_i),
  .pc_o(pc_o), .hlat_o(hlat_o), .ulat_o(ulat_o)
);

// File: tb/test_pc_latch_unit.sv
module test_pc_latch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_i = 0, jmp_i = 0, lo_wr_i = 0, lo_rd_i = 0, hlat_wr_i = 0, ulat_wr_i = 0;
  logic [20:0] jmp_tgt_i = '0;
  logic [7:0]  lo_wdata_i = '0, hlat_wdata_i = '0, ulat_wdata_i = '0;
  logic [20:0] pc_o;
  logic [7:0]  lo_o, hlat_o, ulat_o;

  int checks = 0;
  int errors = 0;
  logic [20:0] m_pc = '0;
  logic [7:0]  m_h = '0;
  logic [4:0]  m_u = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  pc_latch_unit i_pc_latch_unit (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .jmp_i(jmp_i), .jmp_tgt_i(jmp_tgt_i),
    .lo_wr_i(lo_wr_i), .lo_wdata_i(lo_wdata_i), .lo_rd_i(lo_rd_i),
    .hlat_wr_i(hlat_wr_i), .hlat_wdata_i(hlat_wdata_i),
    .ulat_wr_i(ulat_wr_i), .ulat_wdata_i(ulat_wdata_i),
    .pc_o(pc_o), .lo_o(lo_o), .hlat_o(hlat_o), .ulat_o(ulat_o)
  );

  task automatic chk(input string req, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " pc"}, pc_o, m_pc);
    chk({req, " lsb R3"}, {20'd0, pc_o[0]}, 21'd0);
    chk({req, " lo R10"}, {13'd0, lo_o}, {13'd0, m_pc[7:0]});
    chk({req, " hlat"}, {13'd0, hlat_o}, {13'd0, m_h});
    chk({req, " ulat R7"}, {13'd0, ulat_o}, {16'd0, m_u});
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic cyc(input logic a, j, w, r, hw, uw, input logic [20:0] t,
                     input logic [7:0] d, hd, ud, input string req);
    logic [20:0] npc;
    logic [7:0]  nh;
    logic [4:0]  nu;
    adv_i = a; jmp_i = j; lo_wr_i = w; lo_rd_i = r; hlat_wr_i = hw; ulat_wr_i = uw;
    jmp_tgt_i = t; lo_wdata_i = d; hlat_wdata_i = hd; ulat_wdata_i = ud;
    if (w)      npc = {m_u, m_h, d[7:1], 1'b0};
    else if (j) npc = {t[20:1], 1'b0};
    else if (a) npc = m_pc + 21'd2;
    else        npc = m_pc;
    nh = hw ? hd : (r ? m_pc[15:8] : m_h);
    nu = uw ? ud[4:0] : (r ? m_pc[20:16] : m_u);
    @(posedge clk);
    @(negedge clk);
    adv_i = 0; jmp_i = 0; lo_wr_i = 0; lo_rd_i = 0; hlat_wr_i = 0; ulat_wr_i = 0;
    m_pc = npc; m_h = nh; m_u = nu;
    check_all(req);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_all("R1 after reset");

    for (int i = 0; i < 40; i++) cyc(1,0,0,0,0,0, '0, 8'h00, 8'h00, 8'h00, "R2 advance");
    cyc(0,1,0,0,0,0, 21'h1FFFFE, 8'h00, 8'h00, 8'h00, "R6 jump top");
    cyc(1,0,0,0,0,0, '0, 8'h00, 8'h00, 8'h00, "R2 wrap");
    chk("R2 wrap to zero", pc_o, 21'd0);
    cyc(0,1,0,0,0,0, 21'h0ABCDF, 8'h00, 8'h00, 8'h00, "R3 R6 odd target");
    chk("R3 odd target", pc_o, 21'h0ABCDE);
    cyc(0,0,0,0,0,0, '0, 8'h00, 8'h00, 8'h00, "R8 idle hold");

    for (int u = 0; u < 32; u++) begin
      cyc(0,0,0,0,1,1, '0, 8'h00, 8'((u * 53) ^ 8'h5A), {3'b111, 5'(u)}, "R7 latch write");
      cyc(0,0,1,0,0,0, '0, 8'((u * 29) | 1), 8'h00, 8'h00, "R4 low write");
      chk("R4 upper from latch", {16'd0, pc_o[20:16]}, {16'd0, 5'(u)});
      cyc(0,1,0,0,0,0, 21'((u * 40503) ^ 21'h15A5A5), 8'h00, 8'h00, 8'h00, "R6 jump");
      cyc(0,0,0,1,0,0, '0, 8'h00, 8'h00, 8'h00, "R5 read copy");
    end

    for (int rep = 0; rep < 30; rep++) begin
      for (int m = 0; m < 64; m++) begin
        logic [31:0] r1, r2;
        r1 = rnd();
        r2 = rnd();
        cyc(m[0], m[1], m[2], m[3], m[4], m[5], r1[20:0], r2[7:0], r2[15:8], r2[23:16],
            "R8 R9 strobe mix");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule